// File: doc/BRIEF.md
# Supply Undervoltage Sequencer with Turn-Off Threshold Latch

This block sequences power-up and gate-drive enabling for a two-channel synchronous rectifier controller. Four analog comparator flags arrive asynchronously. They report whether the supply is above its turn-on level, whether the supply is below its turn-off level, whether the shared control pin is above a low selection level, and whether that pin is above its enable level. Any enable hysteresis is already applied inside the comparator.

While the supply is down, the block keeps a current sink on the control pin active and asks both gate outputs to be pulled low. When the supply crosses its turn-on level, the block reads the selection comparator once and locks in one of two drain-voltage turn-off thresholds. The choice stays frozen until the supply falls below its turn-off level. Only then is the sampler re-armed, so the next power-up takes a new reading. While the block is running, the same pin serves as a plain enable for gate driving.

Top module: `supply_gate_seq`

## Requirements
- R1: After reset, `pin_sink_on` = 1, `gate_pulldown` = 1, `drive_en` = 0 and `thr_shallow` = 0.
- R2: Every comparator flag passes through two synchronizing flip-flops. A change of `sup_above_on` driven between edges therefore changes the run state, and `pin_sink_on`, at the third rising edge and not earlier.
- R3: `pin_sink_on` is 1 while the sequencer is off and 0 while it is running.
- R4: At turn-on the synchronized `pin_above_sel` is sampled. A value of 0 gives `thr_shallow` = 0, which selects the -25 mV turn-off threshold. A value of 1 gives `thr_shallow` = 1, which selects -12 mV.
- R5: While running, `thr_shallow` does not change, whatever `pin_above_sel` does.
- R6: `drive_en` is 1 only while running and while the synchronized `pin_above_en` is 1. It follows `pin_above_en` in both directions.
- R7: When the synchronized `sup_below_off` is 1, the next state has `drive_en` = 0 and `gate_pulldown` = 1, and the sequencer returns to off.
- R8: With the supply between its two levels (`sup_above_on` = 0, `sup_below_off` = 0), the current state is kept. A running sequencer stays running and an off sequencer stays off.
- R9: Once a supply-off event has occurred, the next turn-on takes a fresh sample, so a different selection level yields a different `thr_shallow`.
- R10: `drive_en` and `gate_pulldown` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_above_on | input | 1 | Raw flag: supply above turn-on level |
| sup_below_off | input | 1 | Raw flag: supply below turn-off level |
| pin_above_sel | input | 1 | Raw flag: control pin above selection level |
| pin_above_en | input | 1 | Raw flag: control pin above enable level (hysteresis applied) |
| pin_sink_on | output | 1 | Turns on the control-pin current sink |
| thr_shallow | output | 1 | Latched threshold: 1 = -12 mV, 0 = -25 mV |
| drive_en | output | 1 | Gate drivers allowed to switch |
| gate_pulldown | output | 1 | Hold both gate outputs low |

## Verification
Power-up is run twice, with the selection flag low and then high, to show that the threshold bit follows the sample rather than a constant. A later power cycle with the flag reversed separates a re-armed sampler from one that was latched only once. After turn-on the selection flag is toggled, which shows whether the latch keeps following the pin. The supply is also parked between its two levels, both while running and while off, to tell real hysteresis apart from a single-level compare, and the enable flag is toggled while running to show that the drive follows it both ways.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

  typedef enum logic {
    PWR_OFF = 1'b0,
    PWR_RUN = 1'b1
  } pwr_state_t;

  localparam int unsigned FLAG_COUNT   = 4;
  localparam int unsigned FLG_SUP_ON   = 0;
  localparam int unsigned FLG_SUP_LOW  = 1;
  localparam int unsigned FLG_PIN_SEL  = 2;
  localparam int unsigned FLG_PIN_EN   = 3;

  // turn-on is taken only from the off state with a clean supply-high reading
  function automatic logic turn_on_event(input pwr_state_t st,
                                         input logic sup_on,
                                         input logic sup_low);
    return (st == PWR_OFF) && sup_on && !sup_low;
  endfunction

  // a low-supply reading while running always forces the off state
  function automatic logic turn_off_event(input pwr_state_t st,
                                          input logic sup_low);
    return (st == PWR_RUN) && sup_low;
  endfunction

  // selection comparator high selects the shallower (-12 mV) threshold
  function automatic logic thr_code(input logic pin_sel);
    return pin_sel;
  endfunction

  function automatic logic drive_allowed(input logic run,
                                         input logic pin_en,
                                         input logic sup_low);
    return run && pin_en && !sup_low;
  endfunction

endpackage

// File: rtl/sgs_flag_sync.sv
module sgs_flag_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= '0;
          else        pipe[g] <= raw_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= '0;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = pipe[LAST];
endmodule

// File: rtl/sgs_pwr_fsm.sv
module sgs_pwr_fsm
  import sgs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sup_on_s,
  input  logic sup_low_s,
  output logic run,
  output logic take_sample,
  output logic went_off
);
  pwr_state_t state_q, state_d;

  assign take_sample = turn_on_event(state_q, sup_on_s, sup_low_s);
  assign went_off    = turn_off_event(state_q, sup_low_s);

  always_comb begin
    state_d = state_q;
    if (take_sample)   state_d = PWR_RUN;
    else if (went_off) state_d = PWR_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PWR_OFF;
    else        state_q <= state_d;
  end

  assign run = (state_q == PWR_RUN);
endmodule

// File: rtl/sgs_thr_latch.sv
module sgs_thr_latch
  import sgs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_sample,
  input  logic rearm,
  input  logic pin_sel_s,
  output logic thr_shallow,
  output logic armed
);
  logic capture;

  assign capture = take_sample && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed       <= 1'b1;
      thr_shallow <= 1'b0;
    end else begin
      if (capture) begin
        thr_shallow <= thr_code(pin_sel_s);
        armed       <= 1'b0;
      end else if (rearm) begin
        armed       <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sgs_drive_gate.sv
module sgs_drive_gate
  import sgs_pkg::*;
(
  input  logic run,
  input  logic pin_en_s,
  input  logic sup_low_s,
  output logic drive_en,
  output logic gate_pulldown,
  output logic pin_sink_on
);
  assign drive_en      = drive_allowed(run, pin_en_s, sup_low_s);
  assign gate_pulldown = !run || sup_low_s;
  assign pin_sink_on   = !run;
endmodule

// File: rtl/supply_gate_seq.sv
module supply_gate_seq
  import sgs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_above_on,
  input  logic sup_below_off,
  input  logic pin_above_sel,
  input  logic pin_above_en,
  output logic pin_sink_on,
  output logic thr_shallow,
  output logic drive_en,
  output logic gate_pulldown
);
  logic [FLAG_COUNT-1:0] flags_raw;
  logic [FLAG_COUNT-1:0] flags_s;
  logic sup_on_s, sup_low_s, pin_sel_s, pin_en_s;
  logic run, take_sample, went_off, armed;

  always_comb begin
    flags_raw              = '0;
    flags_raw[FLG_SUP_ON]  = sup_above_on;
    flags_raw[FLG_SUP_LOW] = sup_below_off;
    flags_raw[FLG_PIN_SEL] = pin_above_sel;
    flags_raw[FLG_PIN_EN]  = pin_above_en;
  end

  sgs_flag_sync #(.WIDTH(FLAG_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (flags_raw),
    .sync_out (flags_s)
  );

  assign sup_on_s  = flags_s[FLG_SUP_ON];
  assign sup_low_s = flags_s[FLG_SUP_LOW];
  assign pin_sel_s = flags_s[FLG_PIN_SEL];
  assign pin_en_s  = flags_s[FLG_PIN_EN];

  sgs_pwr_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sup_on_s    (sup_on_s),
    .sup_low_s   (sup_low_s),
    .run         (run),
    .take_sample (take_sample),
    .went_off    (went_off)
  );

  sgs_thr_latch u_thr (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_sample (take_sample),
    .rearm       (went_off),
    .pin_sel_s   (pin_sel_s),
    .thr_shallow (thr_shallow),
    .armed       (armed)
  );

  sgs_drive_gate u_gate (
    .run           (run),
    .pin_en_s      (pin_en_s),
    .sup_low_s     (sup_low_s),
    .drive_en      (drive_en),
    .gate_pulldown (gate_pulldown),
    .pin_sink_on   (pin_sink_on)
  );
endmodule

// File: rtl/sgs_checker.sv
module sgs_checker (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic take_sample,
  input logic sup_low_s,
  input logic pin_sel_s,
  input logic pin_en_s,
  input logic thr_shallow,
  input logic drive_en,
  input logic gate_pulldown
);
  assert_drive_vs_pulldown_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_en && gate_pulldown));

  assert_thr_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && run) |-> $stable(thr_shallow));

  assert_sample_at_turn_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_sample |=> (thr_shallow == $past(pin_sel_s)));

  assert_low_supply_shutdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sup_low_s |=> (gate_pulldown && !drive_en && !run));

  assert_drive_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (pin_en_s && run));
endmodule

bind supply_gate_seq sgs_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .run           (run),
  .take_sample   (take_sample),
  .sup_low_s     (sup_low_s),
  .pin_sel_s     (pin_sel_s),
  .pin_en_s      (pin_en_s),
  .thr_shallow   (thr_shallow),
  .drive_en      (drive_en),
  .gate_pulldown (gate_pulldown)
);

// File: tb/sim_supply_gate_seq.sv
module sim_supply_gate_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_above_on = 1'b0, sup_below_off = 1'b1;
  logic pin_above_sel = 1'b0, pin_above_en = 1'b0;
  logic pin_sink_on, thr_shallow, drive_en, gate_pulldown;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  supply_gate_seq u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .sup_above_on  (sup_above_on),
    .sup_below_off (sup_below_off),
    .pin_above_sel (pin_above_sel),
    .pin_above_en  (pin_above_en),
    .pin_sink_on   (pin_sink_on),
    .thr_shallow   (thr_shallow),
    .drive_en      (drive_en),
    .gate_pulldown (gate_pulldown)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "sink", pin_sink_on, 1'b1);
    check("R1", "pulldown", gate_pulldown, 1'b1);
    check("R1", "drive", drive_en, 1'b0);
    check("R1", "thr", thr_shallow, 1'b0);
  endtask

  task automatic t_powerup(input logic sel, input logic act);
    pin_above_sel = sel; pin_above_en = act;
    sup_below_off = 1'b0;
    step(4);
    sup_above_on = 1'b1;
    step(2);
    check("R2", "sink before third edge", pin_sink_on, 1'b1);
    step(1);
    check("R3", "sink after turn-on", pin_sink_on, 1'b0);
    check("R4", "thr sample", thr_shallow, sel);
    check("R6", "drive after turn-on", drive_en, act);
    check("R10", "pulldown released", gate_pulldown, 1'b0);
  endtask

  task automatic t_freeze();
    logic held;
    held = thr_shallow;
    pin_above_sel = ~pin_above_sel;
    step(4);
    check("R5", "thr frozen after toggle", thr_shallow, held);
    pin_above_sel = ~pin_above_sel;
    step(4);
    check("R5", "thr frozen after second toggle", thr_shallow, held);
  endtask

  task automatic t_enable();
    pin_above_en = 1'b0;
    step(4);
    check("R6", "drive off with enable low", drive_en, 1'b0);
    pin_above_en = 1'b1;
    step(4);
    check("R6", "drive on with enable high", drive_en, 1'b1);
  endtask

  task automatic t_band_running();
    sup_above_on = 1'b0;
    step(6);
    check("R8", "still running in band", pin_sink_on, 1'b0);
    check("R8", "drive kept in band", drive_en, 1'b1);
  endtask

  task automatic t_off();
    sup_below_off = 1'b1;
    step(3);
    check("R7", "pulldown on low supply", gate_pulldown, 1'b1);
    check("R7", "drive off on low supply", drive_en, 1'b0);
    check("R3", "sink back on", pin_sink_on, 1'b1);
    sup_below_off = 1'b0;
    step(6);
    check("R8", "still off in band", pin_sink_on, 1'b1);
    check("R8", "pulldown kept in band", gate_pulldown, 1'b1);
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_powerup(1'b0, 1'b1);
    t_freeze();
    t_enable();
    t_band_running();
    t_off();
    t_powerup(1'b1, 1'b0);
    check("R9", "fresh sample shallow", thr_shallow, 1'b1);
    t_freeze();
    t_enable();
    sup_above_on = 1'b0;
    t_off();
    t_powerup(1'b0, 1'b1);
    check("R9", "fresh sample deep", thr_shallow, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule